// File: doc/BRIEF.md
# Accumulating Multiply Execution Unit

This unit sits beside the integer pipeline of a 32-bit core and owns one private 64-bit accumulator. Instructions from a custom major opcode drive it: they clear the accumulator, copy one of its halves into a destination register, or multiply the two source operands and add the product into the accumulator. The multiply-accumulate comes in a narrow form, which works on the low 32 bits and zeroes the upper half, and a wide form, which works on all 64 bits. Each form has a signed and an unsigned mode.

The issue side is a valid-only stream. `issue_valid` qualifies the instruction word and both operand values. The unit has no ready output and never applies back-pressure: it accepts an instruction on every rising clock edge where `issue_valid` is high. The result side is a one-cycle strobe with no ready input. The register file must take `wb_en`, `wb_rd` and `wb_data` in the cycle they are presented. Fetch, the register file and hazard handling belong to the surrounding core.

Top module: `acc_mac_unit`

## Requirements
- R1: Only instructions whose bits 6:0 equal 0001011 are acted on. Any other opcode, even with `issue_valid` high, gives no write, no illegal flag and no change to the accumulator. The minor function code is in bits 14:12, the operation variant is in bits 31:25, and the destination index is in bits 11:7.
- R2: Function 0 with variant 0 sets the accumulator to zero and does not request a register write.
- R3: Function 0 with variant 1 writes accumulator bits 31:0 to the destination. Variant 2 writes accumulator bits 63:32. The value returned is the accumulator as it stood before the read.
- R4: Function 1 (variant 0 unsigned, variant 1 signed) adds the low 32 bits of the product of the two operands to accumulator bits 31:0. The 32-bit sum becomes the low half, and the high half becomes zero. No register write is requested.
- R5: Function 2 with variant 0 adds the full unsigned 64-bit product to the accumulator, modulo 2^64.
- R6: Function 2 with variant 1 treats both operands as two's-complement values and adds their 64-bit signed product to the accumulator, modulo 2^64.
- R7: A read of either half whose destination index is 0 keeps `wb_en` low.
- R8: Any other combination of function and variant under the custom opcode raises `illegal` for one cycle. It requests no write and leaves the accumulator unchanged.
- R9: A synchronous active-low reset clears the accumulator and holds `wb_en` and `illegal` low. Instructions issued during reset are ignored.
- R10: An instruction accepted at a clock edge shows its outputs for the following cycle. Its accumulator update is visible to an instruction accepted at the very next edge, so back-to-back instructions need no gap.
- R11: In a cycle where `issue_valid` is low, the next cycle shows `wb_en` and `illegal` low, and the accumulator keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| issue_valid | input | 1 | Instruction and operands are valid this cycle |
| instr | input | 32 | Instruction word |
| src_a | input | 32 | First source operand value |
| src_b | input | 32 | Second source operand value |
| wb_en | output | 1 | Register write request |
| wb_rd | output | 5 | Destination register index |
| wb_data | output | 32 | Register write data |
| illegal | output | 1 | Unsupported instruction under the custom opcode |

## Verification
Every result is due exactly one clock edge after its instruction is accepted. This covers write-back strobes, read data and the illegal flag. The bench drives inputs on the falling edge and samples 1 ns after the next rising edge. Accumulator effects cannot be seen at the ports directly, so they are checked through a read of both halves issued at the very next edge. This confirms the back-to-back visibility of each update and checks the arithmetic against a model computed in the bench.

// File: rtl/acc_mac_pkg.sv
package acc_mac_pkg;

  localparam logic [6:0] CUSTOM_OPC = 7'b0001011;

  localparam logic [2:0] FN_MGMT  = 3'd0;
  localparam logic [2:0] FN_MAC_N = 3'd1;
  localparam logic [2:0] FN_MAC_W = 3'd2;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_CLEAR,
    OP_RD_LO,
    OP_RD_HI,
    OP_MAC_N,
    OP_MAC_W,
    OP_BAD
  } acc_op_e;

  typedef struct packed {
    acc_op_e    op;
    logic       sgn;
    logic [4:0] rd;
  } acc_dec_t;

endpackage

// File: rtl/acc_mac_decode.sv
module acc_mac_decode
  import acc_mac_pkg::*;
(
  input  logic        valid,
  input  logic [31:0] instr,
  output acc_dec_t    dec
);

  logic [6:0] opc;
  logic [2:0] fn;
  logic [6:0] var7;

  assign opc  = instr[6:0];
  assign fn   = instr[14:12];
  assign var7 = instr[31:25];

  always_comb begin
    dec.op  = OP_NONE;
    dec.sgn = 1'b0;
    dec.rd  = instr[11:7];
    if (valid && opc == CUSTOM_OPC) begin
      dec.op = OP_BAD;
      unique case (fn)
        FN_MGMT: begin
          if (var7 == 7'd0)      dec.op = OP_CLEAR;
          else if (var7 == 7'd1) dec.op = OP_RD_LO;
          else if (var7 == 7'd2) dec.op = OP_RD_HI;
        end
        FN_MAC_N, FN_MAC_W: begin
          if (var7 == 7'd0 || var7 == 7'd1) begin
            dec.op  = (fn == FN_MAC_N) ? OP_MAC_N : OP_MAC_W;
            dec.sgn = var7[0];
          end
        end
        default: dec.op = OP_BAD;
      endcase
    end
  end

endmodule

// File: rtl/acc_mac_arith.sv
module acc_mac_arith
  import acc_mac_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  acc_op_e              op,
  input  logic                 sgn,
  input  logic [XLEN-1:0]      a,
  input  logic [XLEN-1:0]      b,
  input  logic [2*XLEN-1:0]    acc,
  output logic [2*XLEN-1:0]    acc_next
);

  localparam int AW = 2 * XLEN;

  logic [AW-1:0] ext_a;
  logic [AW-1:0] ext_b;
  logic [AW-1:0] prod;
  logic [XLEN-1:0] narrow_sum;

  // Extending both operands to the full width first makes the low
  // AW bits of a plain product correct for either signedness.
  assign ext_a = sgn ? {{XLEN{a[XLEN-1]}}, a} : {{XLEN{1'b0}}, a};
  assign ext_b = sgn ? {{XLEN{b[XLEN-1]}}, b} : {{XLEN{1'b0}}, b};
  assign prod  = ext_a * ext_b;

  assign narrow_sum = acc[XLEN-1:0] + prod[XLEN-1:0];

  always_comb begin
    unique case (op)
      OP_CLEAR: acc_next = '0;
      OP_MAC_N: acc_next = {{XLEN{1'b0}}, narrow_sum};
      OP_MAC_W: acc_next = acc + prod;
      default:  acc_next = acc;
    endcase
  end

endmodule

// File: rtl/acc_mac_state.sv
module acc_mac_state
  import acc_mac_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  acc_dec_t             dec,
  input  logic [2*XLEN-1:0]    acc_next,
  output logic [2*XLEN-1:0]    acc,
  output logic                 wb_en,
  output logic [4:0]           wb_rd,
  output logic [XLEN-1:0]      wb_data,
  output logic                 illegal
);

  logic is_read;
  assign is_read = (dec.op == OP_RD_LO) || (dec.op == OP_RD_HI);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc     <= '0;
      wb_en   <= 1'b0;
      wb_rd   <= '0;
      wb_data <= '0;
      illegal <= 1'b0;
    end else begin
      acc     <= acc_next;
      wb_en   <= is_read && (dec.rd != 5'd0);
      wb_rd   <= dec.rd;
      wb_data <= (dec.op == OP_RD_HI) ? acc[2*XLEN-1:XLEN] : acc[XLEN-1:0];
      illegal <= (dec.op == OP_BAD);
    end
  end

  // R7: register zero is never written
  a_r7_no_rd0_write: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (wb_rd != 5'd0));

  // R8: rejected instructions leave the accumulator alone and do not write
  a_r8_bad_keeps_acc: assert property (@(posedge clk) disable iff (!rst_n)
    (dec.op == OP_BAD) |=> (acc == $past(acc)) && illegal && !wb_en);

  // R4: narrow accumulate zeroes the upper half
  a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (dec.op == OP_MAC_N) |=> (acc[2*XLEN-1:XLEN] == '0));

  // R9: reset clears state
  a_r9_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (acc == '0) && !wb_en && !illegal);

  // R11: idle cycles produce nothing and keep the accumulator
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (dec.op == OP_NONE) |=> !wb_en && !illegal && (acc == $past(acc)));

  // R3: read data is the accumulator half held before the read
  a_r3_read_value: assert property (@(posedge clk) disable iff (!rst_n)
    (dec.op == OP_RD_LO) |=> (wb_data == $past(acc[XLEN-1:0])));

  a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wb_en, illegal}));

endmodule

// File: rtl/acc_mac_unit.sv
module acc_mac_unit
  import acc_mac_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            issue_valid,
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] src_a,
  input  logic [XLEN-1:0] src_b,
  output logic            wb_en,
  output logic [4:0]      wb_rd,
  output logic [XLEN-1:0] wb_data,
  output logic            illegal
);

  localparam int AW = 2 * XLEN;

  acc_dec_t      dec;
  logic [AW-1:0] acc;
  logic [AW-1:0] acc_next;

  acc_mac_decode u_dec (
    .valid (issue_valid),
    .instr (instr),
    .dec   (dec)
  );

  acc_mac_arith #(.XLEN(XLEN)) u_arith (
    .op       (dec.op),
    .sgn      (dec.sgn),
    .a        (src_a),
    .b        (src_b),
    .acc      (acc),
    .acc_next (acc_next)
  );

  acc_mac_state #(.XLEN(XLEN)) u_state (
    .clk      (clk),
    .rst_n    (rst_n),
    .dec      (dec),
    .acc_next (acc_next),
    .acc      (acc),
    .wb_en    (wb_en),
    .wb_rd    (wb_rd),
    .wb_data  (wb_data),
    .illegal  (illegal)
  );

endmodule

// File: tb/tb_acc_mac_unit.sv
`timescale 1ns/1ps
module tb_acc_mac_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] src_a = '0;
  logic [31:0] src_b = '0;
  logic        wb_en;
  logic [4:0]  wb_rd;
  logic [31:0] wb_data;
  logic        illegal;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;
  logic [63:0] model = '0;

  always #2 clk = ~clk;

  acc_mac_unit dut (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .instr(instr),
    .src_a(src_a), .src_b(src_b), .wb_en(wb_en), .wb_rd(wb_rd),
    .wb_data(wb_data), .illegal(illegal)
  );

  function automatic logic [31:0] enc(input logic [6:0] v7, input logic [2:0] f3,
                                      input logic [4:0] rd, input logic [6:0] opc);
    return {v7, 5'd3, 5'd4, f3, rd, opc};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Issue one instruction under the custom opcode and check its outputs.
  task automatic op(input string tag, input logic [6:0] v7, input logic [2:0] f3,
                    input logic [4:0] rd, input logic [31:0] a, input logic [31:0] b);
    logic legal, rdop, en;
    logic [31:0] d;
    logic [63:0] p;
    legal = (f3 == 3'd0 && v7 <= 7'd2) || ((f3 == 3'd1 || f3 == 3'd2) && v7 <= 7'd1);
    rdop  = legal && f3 == 3'd0 && v7 != 7'd0;
    en    = rdop && rd != 5'd0;
    d     = (v7 == 7'd2) ? model[63:32] : model[31:0];
    @(negedge clk);
    issue_valid = 1'b1; instr = enc(v7, f3, rd, 7'b0001011); src_a = a; src_b = b;
    @(posedge clk); #1;
    chk({tag, " illegal"}, 64'(illegal), 64'(!legal));
    chk({tag, " wb_en"}, 64'(wb_en), 64'(en));
    if (en) begin
      chk({tag, " wb_rd"}, 64'(wb_rd), 64'(rd));
      chk({tag, " wb_data"}, 64'(wb_data), 64'(d));
    end
    if (legal) begin
      if (v7 <= 7'd1) p = {{32{a[31] & v7[0]}}, a} * {{32{b[31] & v7[0]}}, b};
      else p = '0;
      if (f3 == 3'd0 && v7 == 7'd0) model = '0;
      else if (f3 == 3'd1) model = {32'd0, model[31:0] + p[31:0]};
      else if (f3 == 3'd2) model = model + p;
    end
  endtask

  // Read both halves back at the next edges (R10 back-to-back).
  task automatic readback(input string tag);
    op({tag, " R3 lo"}, 7'd1, 3'd0, 5'd9, 32'h0, 32'h0);
    op({tag, " R3 hi"}, 7'd2, 3'd0, 5'd10, 32'h0, 32'h0);
  endtask

  initial begin : watchdog
    #(4 * 150000);
    if (!done) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] vals [8];
    logic [6:0]  v7s [6];
    vals = '{32'h0, 32'h1, 32'hffffffff, 32'h7fffffff, 32'h80000000,
             32'h12345678, 32'hdeadbeef, 32'h0000ffff};
    v7s  = '{7'd0, 7'd1, 7'd2, 7'd3, 7'd64, 7'd127};

    // R9: reset, with a wide MAC issued during reset that must be ignored
    @(negedge clk);
    issue_valid = 1'b1; instr = enc(7'd0, 3'd2, 5'd1, 7'b0001011);
    src_a = 32'h1234; src_b = 32'h5678;
    repeat (3) @(posedge clk);
    #1;
    chk("R9 wb_en in reset", 64'(wb_en), 64'd0);
    chk("R9 illegal in reset", 64'(illegal), 64'd0);
    @(negedge clk); rst_n = 1'b1; issue_valid = 1'b0;
    readback("R9 after reset");

    // R5 / R6 / R4: sweep of all operand pairs in every MAC mode
    for (int m = 0; m < 4; m++) begin
      op("R2 clear", 7'd0, 3'd0, 5'd3, 32'h0, 32'h0);
      readback("R2");
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++) begin
          op((m < 2) ? "R4 mac narrow" : (m == 2 ? "R5 mac wide u" : "R6 mac wide s"),
             7'(m % 2), (m < 2) ? 3'd1 : 3'd2, 5'd0, vals[i], vals[j]);
          readback((m < 2) ? "R4 R10" : (m == 2 ? "R5 R10" : "R6 R10"));
        end
    end

    // R4: narrow MAC after a wide one zeroes the upper half
    op("R6 preload", 7'd1, 3'd2, 5'd0, 32'h80000000, 32'h7fffffff);
    op("R4 zero hi", 7'd0, 3'd1, 5'd0, 32'h2, 32'h3);
    readback("R4 zero hi");

    // R7: reads to register zero
    op("R7 lo rd0", 7'd1, 3'd0, 5'd0, 32'h0, 32'h0);
    op("R7 hi rd0", 7'd2, 3'd0, 5'd0, 32'h0, 32'h0);

    // R8: sweep of function/variant combinations
    op("R8 preload", 7'd1, 3'd2, 5'd0, 32'hfedcba98, 32'h01234567);
    for (int f = 0; f < 8; f++)
      for (int k = 0; k < 6; k++) begin
        if ((f == 0 && v7s[k] <= 7'd2) || ((f == 1 || f == 2) && v7s[k] <= 7'd1)) continue;
        op("R8 illegal", v7s[k], 3'(f), 5'd5, 32'h11, 32'h22);
        readback("R8 acc kept");
      end

    // R1: foreign opcode ignored
    @(negedge clk);
    issue_valid = 1'b1; instr = enc(7'd0, 3'd2, 5'd7, 7'b0101011);
    src_a = 32'h99; src_b = 32'h77;
    @(posedge clk); #1;
    chk("R1 wb_en", 64'(wb_en), 64'd0);
    chk("R1 illegal", 64'(illegal), 64'd0);
    readback("R1 acc kept");

    // R11: valid low with a MAC on the bus
    @(negedge clk);
    issue_valid = 1'b0; instr = enc(7'd0, 3'd2, 5'd0, 7'b0001011);
    src_a = 32'h55; src_b = 32'h66;
    @(posedge clk); #1;
    chk("R11 wb_en", 64'(wb_en), 64'd0);
    chk("R11 illegal", 64'(illegal), 64'd0);
    readback("R11 acc kept");

    @(negedge clk); issue_valid = 1'b0;
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule